// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between an 8-bit processor bus (16-bit address, 8-bit data, separate read and write strobes) and a cartridge holding a banked ROM and an optional external RAM. Writes that land in the ROM address range never reach memory. They update four control fields: a RAM enable flag, a 5-bit low ROM bank, a 2-bit secondary bank, and a banking-mode bit. Reads in the ROM range are turned into a linear ROM byte address. Reads and writes in the 8 KiB RAM window are turned into a RAM byte address, or blocked.

The secondary bank serves two purposes. It always supplies the upper bank bits of the switchable 16 KiB ROM window. With the mode bit set, it also re-banks the fixed lower ROM window and selects one of four 8 KiB RAM banks. ROM size and RAM size come from configuration inputs. The ROM size trims every bank number to the banks that exist. The RAM size decides how the RAM window wraps, and whether RAM exists at all.

Register updates take effect at the clock edge of the write. All address translation and the RAM-window read data are combinational from the current register state.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write to 0x0000–0x1FFF sets the RAM enable flag when data bits [3:0] equal 0xA and clears it for any other value; bits [7:4] are ignored.
- R2: A write to 0x2000–0x3FFF loads the low bank: 1 when data bits [4:0] are zero, otherwise data[4:0] ANDed with the ROM bank mask (2^cfg_rom_banks_log2 − 1). The zero test is made before masking, so a masked result of 0 is kept.
- R3: A write to 0x4000–0x5FFF loads the secondary bank from data[1:0]; a write to 0x6000–0x7FFF loads the mode bit from data[0]; the new value is visible from the cycle after the write.
- R4: A read in 0x4000–0x7FFF drives rom_addr = 0x4000 × (({secondary, low}) AND mask) + (addr − 0x4000), with rom_rd high.
- R5: A read in 0x0000–0x3FFF drives rom_addr = addr in mode 0, and 0x4000 × ((secondary × 32) AND mask) + addr in mode 1.
- R6: A read in 0xA000–0xBFFF with RAM enabled and present (cfg_ram_kind ≠ 0) raises ram_re and returns ram_rdata on cpu_rdata; otherwise ram_re stays low and cpu_rdata is 0xFF.
- R7: A write in 0xA000–0xBFFF raises ram_we (with ram_wdata = bus data) only when RAM is enabled and present; otherwise ram_we stays low.
- R8: With cfg_ram_kind = 3 (32 KiB), ram_addr is 0x2000 × secondary + (addr − 0xA000) in mode 1, and addr − 0xA000 in mode 0.
- R9: With cfg_ram_kind = 1 (2 KiB) or 2 (8 KiB), ram_addr is (addr − 0xA000) modulo the RAM size, whatever the mode and secondary bank.
- R10: After reset the low bank is 1, the secondary bank and mode are 0, and RAM is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rom_banks_log2 | input | 3 | log2 of the number of 16 KiB ROM banks present |
| cfg_ram_kind | input | 2 | RAM size: 0 none, 1 2 KiB, 2 8 KiB, 3 32 KiB |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Processor write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | RAM-window read data, 0xFF when blocked |
| rom_rd | output | 1 | ROM read request |
| rom_addr | output | 21 | Linear ROM byte address |
| ram_re | output | 1 | RAM read request |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 15 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | Data returned by the RAM |

## Verification
Every translated address and strobe is combinational, so the bench samples rom_addr, ram_addr, ram_re, ram_we and cpu_rdata one nanosecond after it drives the bus, within the same cycle and well before the next edge. A control-register write is captured at the rising edge that follows the drive. The bench therefore checks its effect only with a read issued at the next falling edge or later, one cycle after the write. The model of the RAM's read data is a fixed function of ram_addr, so cpu_rdata is checked in the same cycle as the read.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [1:0] {
    RAM_NONE = 2'd0,
    RAM_2K   = 2'd1,
    RAM_8K   = 2'd2,
    RAM_32K  = 2'd3
  } ram_kind_e;

  // bus_addr[15:13] of the external RAM window
  localparam logic [2:0] RAM_WIN_TAG = 3'b101;

  // bus_addr[14:13] select among the four control fields when bus_addr[15] is 0
  localparam logic [1:0] CTL_ENABLE = 2'd0;
  localparam logic [1:0] CTL_LOW    = 2'd1;
  localparam logic [1:0] CTL_SEC    = 2'd2;
  localparam logic [1:0] CTL_MODE   = 2'd3;

endpackage

// File: rtl/cbm_ctrl_regs.sv
module cbm_ctrl_regs #(
  parameter int LOW_W  = 5,
  parameter int SEC_W  = 2,
  localparam int BANK_W = LOW_W + SEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_sel,
  input  logic [LOW_W-1:0]  wdata_lo,
  input  logic [BANK_W-1:0] rom_mask,
  output logic              ram_en_q,
  output logic [LOW_W-1:0]  low_q,
  output logic [SEC_W-1:0]  sec_q,
  output logic              mode_q,
  output logic              wr_en_evt,
  output logic              wr_bank_evt,
  output logic              wr_sec_evt,
  output logic              wr_mode_evt
);
  import cbm_pkg::*;

  // zero test on the raw field, mask applied only to non-zero values
  function automatic logic [LOW_W-1:0] low_bank_next(input logic [LOW_W-1:0] d,
                                                     input logic [LOW_W-1:0] m);
    if (d == '0) return LOW_W'(1);
    return d & m;
  endfunction

  assign wr_en_evt   = ctl_wr && (ctl_sel == CTL_ENABLE);
  assign wr_bank_evt = ctl_wr && (ctl_sel == CTL_LOW);
  assign wr_sec_evt  = ctl_wr && (ctl_sel == CTL_SEC);
  assign wr_mode_evt = ctl_wr && (ctl_sel == CTL_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en_q <= 1'b0;
      low_q    <= LOW_W'(1);
      sec_q    <= '0;
      mode_q   <= 1'b0;
    end else begin
      if (wr_en_evt)   ram_en_q <= (wdata_lo[3:0] == 4'hA);
      if (wr_bank_evt) low_q    <= low_bank_next(wdata_lo, rom_mask[LOW_W-1:0]);
      if (wr_sec_evt)  sec_q    <= wdata_lo[SEC_W-1:0];
      if (wr_mode_evt) mode_q   <= wdata_lo[0];
    end
  end

endmodule

// File: rtl/cbm_rom_map.sv
module cbm_rom_map #(
  parameter int LOW_W  = 5,
  parameter int SEC_W  = 2,
  parameter int WIN_AW = 14,
  localparam int BANK_W = LOW_W + SEC_W,
  localparam int ROM_AW = BANK_W + WIN_AW
) (
  input  logic              upper_win,
  input  logic [WIN_AW-1:0] win_off,
  input  logic [LOW_W-1:0]  low_q,
  input  logic [SEC_W-1:0]  sec_q,
  input  logic              mode_q,
  input  logic [BANK_W-1:0] rom_mask,
  output logic [ROM_AW-1:0] rom_addr
);

  function automatic logic [BANK_W-1:0] high_bank(input logic [SEC_W-1:0] s,
                                                  input logic [LOW_W-1:0] l,
                                                  input logic [BANK_W-1:0] m);
    return {s, l} & m;
  endfunction

  function automatic logic [BANK_W-1:0] zero_bank(input logic [SEC_W-1:0] s,
                                                  input logic [BANK_W-1:0] m);
    return {s, {LOW_W{1'b0}}} & m;
  endfunction

  logic [BANK_W-1:0] bank_sel;

  always_comb begin
    if (upper_win)   bank_sel = high_bank(sec_q, low_q, rom_mask);
    else if (mode_q) bank_sel = zero_bank(sec_q, rom_mask);
    else             bank_sel = '0;
  end

  assign rom_addr = {bank_sel, win_off};

endmodule

// File: rtl/cbm_ram_map.sv
module cbm_ram_map #(
  parameter int SEC_W  = 2,
  parameter int WIN_AW = 13,
  localparam int RAM_AW   = SEC_W + WIN_AW,
  localparam int SMALL_AW = WIN_AW - 2
) (
  input  logic              [WIN_AW-1:0] win_off,
  input  cbm_pkg::ram_kind_e              kind,
  input  logic              [SEC_W-1:0]  sec_q,
  input  logic                           mode_q,
  output logic              [RAM_AW-1:0] ram_addr
);
  import cbm_pkg::*;

  function automatic logic [RAM_AW-1:0] ram_offset(input ram_kind_e k,
                                                   input logic m,
                                                   input logic [SEC_W-1:0] s,
                                                   input logic [WIN_AW-1:0] o);
    case (k)
      RAM_2K:  return RAM_AW'(o[SMALL_AW-1:0]);
      RAM_32K: return m ? {s, o} : RAM_AW'(o);
      default: return RAM_AW'(o);
    endcase
  endfunction

  assign ram_addr = ram_offset(kind, mode_q, sec_q, win_off);

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int LOW_W      = 5,
  parameter int SEC_W      = 2,
  parameter int ROM_WIN_AW = 14,
  parameter int RAM_WIN_AW = 13,
  localparam int BANK_W    = LOW_W + SEC_W,
  localparam int ROM_AW    = BANK_W + ROM_WIN_AW,
  localparam int RAM_AW    = SEC_W + RAM_WIN_AW,
  localparam int ROM_CFG_W = $clog2(BANK_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROM_CFG_W-1:0] cfg_rom_banks_log2,
  input  logic [1:0]           cfg_ram_kind,
  input  logic [15:0]          bus_addr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [7:0]           cpu_rdata,
  output logic                 rom_rd,
  output logic [ROM_AW-1:0]    rom_addr,
  output logic                 ram_re,
  output logic                 ram_we,
  output logic [RAM_AW-1:0]    ram_addr,
  output logic [7:0]           ram_wdata,
  input  logic [7:0]           ram_rdata
);
  import cbm_pkg::*;

  logic              in_rom, in_ram, ram_ok;
  logic [BANK_W-1:0] rom_mask;
  logic              ram_en_q, mode_q;
  logic [LOW_W-1:0]  low_q;
  logic [SEC_W-1:0]  sec_q;
  logic              wr_en_evt, wr_bank_evt, wr_sec_evt, wr_mode_evt;
  ram_kind_e         kind;

  assign kind   = ram_kind_e'(cfg_ram_kind);
  assign in_rom = ~bus_addr[15];
  assign in_ram = (bus_addr[15:13] == RAM_WIN_TAG);

  always_comb begin
    if (int'(cfg_rom_banks_log2) >= BANK_W) rom_mask = '1;
    else rom_mask = BANK_W'((32'd1 << cfg_rom_banks_log2) - 32'd1);
  end

  cbm_ctrl_regs #(.LOW_W(LOW_W), .SEC_W(SEC_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (bus_wr && in_rom),
    .ctl_sel     (bus_addr[14:13]),
    .wdata_lo    (bus_wdata[LOW_W-1:0]),
    .rom_mask    (rom_mask),
    .ram_en_q    (ram_en_q),
    .low_q       (low_q),
    .sec_q       (sec_q),
    .mode_q      (mode_q),
    .wr_en_evt   (wr_en_evt),
    .wr_bank_evt (wr_bank_evt),
    .wr_sec_evt  (wr_sec_evt),
    .wr_mode_evt (wr_mode_evt)
  );

  cbm_rom_map #(.LOW_W(LOW_W), .SEC_W(SEC_W), .WIN_AW(ROM_WIN_AW)) u_rom (
    .upper_win (bus_addr[ROM_WIN_AW]),
    .win_off   (bus_addr[ROM_WIN_AW-1:0]),
    .low_q     (low_q),
    .sec_q     (sec_q),
    .mode_q    (mode_q),
    .rom_mask  (rom_mask),
    .rom_addr  (rom_addr)
  );

  cbm_ram_map #(.SEC_W(SEC_W), .WIN_AW(RAM_WIN_AW)) u_ram (
    .win_off  (bus_addr[RAM_WIN_AW-1:0]),
    .kind     (kind),
    .sec_q    (sec_q),
    .mode_q   (mode_q),
    .ram_addr (ram_addr)
  );

  assign ram_ok    = ram_en_q && (kind != RAM_NONE);
  assign rom_rd    = bus_rd && in_rom;
  assign ram_re    = bus_rd && in_ram && ram_ok;
  assign ram_we    = bus_wr && in_ram && ram_ok;
  assign ram_wdata = bus_wdata;
  assign cpu_rdata = ram_re ? ram_rdata : 8'hFF;

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int LOW_W  = 5,
  parameter int SEC_W  = 2,
  parameter int ROM_AW = 21,
  localparam int BANK_W = LOW_W + SEC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       bus_addr,
  input logic [LOW_W-1:0]  wdata_lo,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        cfg_ram_kind,
  input logic [BANK_W-1:0] rom_mask,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [7:0]        cpu_rdata,
  input logic              ram_re,
  input logic              ram_we,
  input logic              in_ram,
  input logic              ram_ok,
  input logic              ram_en_q,
  input logic [LOW_W-1:0]  low_q,
  input logic [SEC_W-1:0]  sec_q,
  input logic              mode_q,
  input logic              wr_en_evt,
  input logic              wr_bank_evt,
  input logic              wr_sec_evt,
  input logic              wr_mode_evt
);

  p_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_evt |=> ram_en_q == ($past(wdata_lo[3:0]) == 4'hA));

  p_bank_fix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bank_evt && wdata_lo == '0) |=> low_q == LOW_W'(1));

  p_bank_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bank_evt && wdata_lo != '0) |=>
      (low_q & ~$past(rom_mask[LOW_W-1:0])) == '0);

  p_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec_evt |=> sec_q == $past(wdata_lo[SEC_W-1:0]));

  p_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode_evt |=> mode_q == $past(wdata_lo[0]));

  p_low_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[15:14] == 2'b00 && !mode_q) |->
      ((rom_addr >> 14) == '0 && rom_addr[13:0] == bus_addr[13:0]));

  p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_ram && !ram_ok) |-> (cpu_rdata == 8'hFF && !ram_re));

  p_write_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (bus_wr && ram_en_q && cfg_ram_kind != 2'd0));

endmodule

bind cart_bank_mapper cbm_checker #(.LOW_W(LOW_W), .SEC_W(SEC_W), .ROM_AW(ROM_AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .wdata_lo     (bus_wdata[LOW_W-1:0]),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .cfg_ram_kind (cfg_ram_kind),
  .rom_mask     (rom_mask),
  .rom_addr     (rom_addr),
  .cpu_rdata    (cpu_rdata),
  .ram_re       (ram_re),
  .ram_we       (ram_we),
  .in_ram       (in_ram),
  .ram_ok       (ram_ok),
  .ram_en_q     (ram_en_q),
  .low_q        (low_q),
  .sec_q        (sec_q),
  .mode_q       (mode_q),
  .wr_en_evt    (wr_en_evt),
  .wr_bank_evt  (wr_bank_evt),
  .wr_sec_evt   (wr_sec_evt),
  .wr_mode_evt  (wr_mode_evt)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_rom_banks_log2 = 3'd7;
  logic [1:0]  cfg_ram_kind = 2'd3;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        rom_rd;
  logic [20:0] rom_addr;
  logic        ram_re, ram_we;
  logic [14:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        wr_probe_we;
  logic [14:0] wr_probe_addr;
  logic [7:0]  wr_probe_data;

  always #2.5 clk = ~clk;

  // RAM model: read data is a fixed function of the address
  function automatic logic [7:0] ram_pattern(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  assign ram_rdata = ram_pattern(ram_addr);

  cart_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_rom_banks_log2(cfg_rom_banks_log2), .cfg_ram_kind(cfg_ram_kind),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .cpu_rdata(cpu_rdata), .rom_rd(rom_rd), .rom_addr(rom_addr),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    wr_probe_we = ram_we; wr_probe_addr = ram_addr; wr_probe_data = ram_wdata;
    @(posedge clk);
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    #1;
  endtask

  task automatic rom_chk(input string req, input logic [15:0] a, input logic [20:0] exp);
    do_read(a);
    chk(req, "rom_addr", 32'(rom_addr), 32'(exp));
    chk(req, "rom_rd", 32'(rom_rd), 32'd1);
  endtask

  task automatic ram_chk(input string req, input logic [15:0] a, input logic [14:0] exp);
    do_read(a);
    chk(req, "ram_addr", 32'(ram_addr), 32'(exp));
    chk(req, "ram_re", 32'(ram_re), 32'd1);
    chk(req, "cpu_rdata", 32'(cpu_rdata), 32'(ram_pattern(exp)));
  endtask

  task automatic blk_chk(input string req, input logic [15:0] a);
    do_read(a);
    chk(req, "cpu_rdata", 32'(cpu_rdata), 32'h0000_00FF);
    chk(req, "ram_re", 32'(ram_re), 32'd0);
  endtask

  // {op, req, addr, data, expected}; op 0 write, 1 ROM check, 2 RAM check, 3 blocked read
  localparam int NV = 19;
  localparam logic [53:0] VEC [0:NV-1] = '{
    {2'd1, 4'd4,  16'h4123, 8'h00, 24'h004123},  // R4 reset bank 1
    {2'd0, 4'd2,  16'h2000, 8'h00, 24'h000000},  // R2 zero -> 1
    {2'd1, 4'd2,  16'h7FFF, 8'h00, 24'h007FFF},
    {2'd0, 4'd2,  16'h2100, 8'h15, 24'h000000},
    {2'd1, 4'd4,  16'h4001, 8'h00, 24'h054001},
    {2'd0, 4'd3,  16'h4000, 8'hFE, 24'h000000},  // R3 secondary = 2
    {2'd1, 4'd4,  16'h4001, 8'h00, 24'h154001},
    {2'd1, 4'd5,  16'h0010, 8'h00, 24'h000010},
    {2'd0, 4'd3,  16'h6000, 8'h01, 24'h000000},  // mode 1
    {2'd1, 4'd5,  16'h0010, 8'h00, 24'h100010},
    {2'd0, 4'd2,  16'h2000, 8'h20, 24'h000000},  // R2 low field zero -> 1
    {2'd1, 4'd4,  16'h4000, 8'h00, 24'h104000},
    {2'd3, 4'd6,  16'hA005, 8'h00, 24'h000000},  // R6 disabled
    {2'd0, 4'd1,  16'h0000, 8'h1A, 24'h000000},  // R1 enable
    {2'd2, 4'd8,  16'hA005, 8'h00, 24'h004005},  // R8 mode 1
    {2'd0, 4'd3,  16'h6000, 8'h00, 24'h000000},
    {2'd2, 4'd8,  16'hBFFF, 8'h00, 24'h001FFF},  // R8 mode 0
    {2'd0, 4'd1,  16'h0000, 8'h0B, 24'h000000},  // R1 disable
    {2'd3, 4'd6,  16'hB000, 8'h00, 24'h000000}
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rom_chk("R10", 16'h4000, 21'h004000);
    rom_chk("R10", 16'h0123, 21'h000123);
    blk_chk("R10", 16'hA000);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [15:0] a;
      logic [7:0]  d;
      logic [23:0] e;
      {op, rq, a, d, e} = VEC[i];
      case (op)
        2'd0: do_write(a, d);
        2'd1: rom_chk($sformatf("R%0d", rq), a, e[20:0]);
        2'd2: ram_chk($sformatf("R%0d", rq), a, e[14:0]);
        default: blk_chk($sformatf("R%0d", rq), a);
      endcase
    end

    // R2 mask after the zero test: 4 banks, data 0x04 -> bank 0
    cfg_rom_banks_log2 = 3'd2;
    do_write(16'h2000, 8'h04);
    rom_chk("R2", 16'h4000, 21'h000000);
    do_write(16'h3FFF, 8'h07);
    rom_chk("R4", 16'h4010, 21'h00C010);

    // R4 / R5 masking of the secondary bits
    cfg_rom_banks_log2 = 3'd5;
    do_write(16'h5000, 8'h03);
    do_write(16'h2000, 8'h1E);
    rom_chk("R4", 16'h4000, 21'h078000);
    do_write(16'h7000, 8'h01);
    rom_chk("R5", 16'h0000, 21'h000000);
    cfg_rom_banks_log2 = 3'd7;
    rom_chk("R5", 16'h0000, 21'h180000);
    rom_chk("R4", 16'h7FFF, 21'h1FBFFF);

    // R9 small RAM wrap, mode 1 secondary 3 ignored
    do_write(16'h1000, 8'h0A);
    cfg_ram_kind = 2'd1;
    ram_chk("R9", 16'hA900, 15'h0100);
    ram_chk("R9", 16'hBFFF, 15'h07FF);
    cfg_ram_kind = 2'd2;
    ram_chk("R9", 16'hBFFF, 15'h1FFF);
    cfg_ram_kind = 2'd3;
    ram_chk("R8", 16'hA001, 15'h6001);

    // R7 write gating
    do_write(16'hA123, 8'h5C);
    chk("R7", "ram_we", 32'(wr_probe_we), 32'd1);
    chk("R7", "ram_addr", 32'(wr_probe_addr), 32'h6123);
    chk("R7", "ram_wdata", 32'(wr_probe_data), 32'h5C);
    cfg_ram_kind = 2'd0;
    blk_chk("R6", 16'hA000);
    do_write(16'hA123, 8'h77);
    chk("R7", "ram_we no RAM", 32'(wr_probe_we), 32'd0);

    // R1 only the low nibble matters
    cfg_ram_kind = 2'd3;
    do_write(16'h0000, 8'hA0);
    blk_chk("R1", 16'hA000);
    do_write(16'h0000, 8'h3A);
    ram_chk("R1", 16'hA000, 15'h6000);
    do_write(16'h0000, 8'hA0);
    do_write(16'hA010, 8'h11);
    chk("R7", "ram_we disabled", 32'(wr_probe_we), 32'd0);

    // R3 only data bit 0 / bits [1:0] are used
    do_write(16'h1FFF, 8'hFA);
    do_write(16'h6000, 8'hFE);
    ram_chk("R3", 16'hA001, 15'h0001);
    do_write(16'h4000, 8'hFD);
    do_write(16'h6000, 8'h03);
    ram_chk("R3", 16'hA000, 15'h2000);

    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule